// File: doc/BRIEF.md
# Low-Speed USB Device Transaction Responder

This block sits between a low-speed USB packet receiver and the transmitter. It picks the reply to each packet that arrives. When the receiver signals the end of a packet, it presents three things: the packet identifier byte, the byte after it, and the packet length in bytes (identifier and CRC included). The responder answers with one of four outcomes:

- no reply at all;
- an ACK handshake;
- a NAK handshake;
- a request to transmit the data buffer the application has prepared.

The responder keeps the identifier of the most recent accepted SETUP or OUT token, so that it can qualify the DATA packet that follows. It also owns four pieces of state: the flag for a full receive buffer, the ready flag and length of the transmit buffer, and the active and pending device addresses.

Data packets are handled before any address comparison. Only a data packet that follows a token for this device is taken. When such a packet is taken, its length and the kind of token are latched for the application and the receive bank is swapped. A new device address written by the application takes effect only when a data reply to an IN token is actually sent. This lets a status stage finish at the old address. The decision is registered once, so the reply request appears one clock after the end-of-packet strobe. That is far inside the turnaround limit of 7.5 low-speed bit times.

Top module: `usb_txn_responder`

## Requirements
- R1: After reset, `reply_valid`, `rx_full` and `tx_ready` are 0, `dev_addr` is 0 and no token is held, so a DATA packet arriving first gets no reply.
- R2: `reply_valid` is a single-cycle pulse. It is high in exactly the cycle after a cycle with `pkt_end` high whose outcome is a reply. `reply_kind` encodes 1 = ACK, 2 = NAK, 3 = send data.
- R3: A packet with `pkt_len` below 3 gets no reply and clears the held token.
- R4: A packet with identifier 0xC3 or 0x4B is a data packet and is never checked against the address. If no token is held, it gets no reply and changes no state.
- R5: A data packet that arrives while a token is held and `rx_full` is 1 gets NAK. `rx_len`, `rx_token` and `rx_bank` keep their values.
- R6: A data packet that arrives while a token is held and `rx_full` is 0 gets ACK. In the same update, `rx_len` takes `pkt_len`, `rx_token` takes the held token identifier, `rx_bank` toggles and `rx_full` becomes 1.
- R7: For any other identifier, `pkt_addr[6:0]` is compared with `dev_addr` and `pkt_addr[7]` is ignored. On a mismatch there is no reply and the held token is cleared.
- R8: A matching SETUP (0x2D) or OUT (0xE1) token is stored as the held token and gets no reply.
- R9: A matching IN (0x69) token gets NAK when `tx_ready` is 0 or `rx_full` is 1. Otherwise it gets a send-data reply with `reply_len` equal to the loaded transmit length, and `tx_ready` clears.
- R10: A value written with `addr_set` is held as pending. It moves into `dev_addr` only on a send-data reply to IN, and never on a NAK.
- R11: A matching packet with an unknown identifier gets no reply and clears the held token.
- R12: `rx_release` clears `rx_full`. `tx_load` sets `tx_ready` and captures `tx_load_len`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_end | input | 1 | End-of-packet strobe from the receiver, one cycle |
| pkt_pid | input | 8 | Packet identifier byte |
| pkt_addr | input | 8 | Second packet byte (address field for tokens) |
| pkt_len | input | LEN_W | Received length in bytes |
| rx_release | input | 1 | Application has consumed the receive buffer |
| tx_load | input | 1 | Application has prepared the transmit buffer |
| tx_load_len | input | LEN_W | Length of the prepared transmit packet |
| addr_set | input | 1 | Write strobe for the pending device address |
| addr_set_val | input | 7 | New device address |
| reply_valid | output | 1 | Reply request, one cycle |
| reply_kind | output | 2 | 1 ACK, 2 NAK, 3 send data |
| reply_len | output | LEN_W | Transmit length for a send-data reply |
| rx_full | output | 1 | Receive buffer holds unprocessed data |
| rx_len | output | LEN_W | Length of the accepted data packet |
| rx_token | output | 8 | Token identifier that preceded the accepted data |
| rx_bank | output | 1 | Receive bank the receiver fills next |
| tx_ready | output | 1 | Transmit buffer loaded and not yet sent |
| dev_addr | output | 7 | Active device address |

## Verification
The assertions assume that `pkt_end` is high for only one cycle per packet. They also assume that `rx_release`, `tx_load` and `addr_set` never share a cycle with `pkt_end`. That second condition keeps each state change tied to a single cause, so the assertions can name the reply that caused it. The bench drives every strobe from its own task on the falling edge. It completes each packet and checks its results before it raises any application strobe, so the stimulus never has the application and the receiver acting in the same cycle.

// File: rtl/usb_resp_pkg.sv
package usb_resp_pkg;

  localparam logic [7:0] PID_DATA0 = 8'hC3;
  localparam logic [7:0] PID_DATA1 = 8'h4B;
  localparam logic [7:0] PID_SETUP = 8'h2D;
  localparam logic [7:0] PID_OUT   = 8'hE1;
  localparam logic [7:0] PID_IN    = 8'h69;
  localparam logic [7:0] TOK_NONE  = 8'h00;

  typedef enum logic [1:0] {
    RK_NONE = 2'd0,
    RK_ACK  = 2'd1,
    RK_NAK  = 2'd2,
    RK_DATA = 2'd3
  } reply_kind_e;

  function automatic logic pid_is_data(input logic [7:0] pid);
    return (pid == PID_DATA0) || (pid == PID_DATA1);
  endfunction

  function automatic logic pid_is_rx_token(input logic [7:0] pid);
    return (pid == PID_SETUP) || (pid == PID_OUT);
  endfunction

  function automatic logic pid_is_in(input logic [7:0] pid);
    return pid == PID_IN;
  endfunction

  // Only the seven address bits take part in the match.
  function automatic logic addr_hits(input logic [7:0] field, input logic [6:0] own);
    return field[6:0] == own;
  endfunction

endpackage

// File: rtl/resp_classify.sv
module resp_classify
  import usb_resp_pkg::*;
#(
  parameter int LEN_W   = 4,
  parameter int MIN_LEN = 3
) (
  input  logic [7:0]       pid,
  input  logic [7:0]       addr_field,
  input  logic [LEN_W-1:0] len,
  input  logic [6:0]       own_addr,
  output logic             cls_short,
  output logic             cls_data,
  output logic             cls_match,
  output logic             cls_in,
  output logic             cls_rxtok
);

  localparam logic [LEN_W-1:0] MinLenV = LEN_W'(MIN_LEN);

  always_comb begin
    cls_short = len < MinLenV;
    cls_data  = pid_is_data(pid);
    cls_match = addr_hits(addr_field, own_addr);
    cls_in    = pid_is_in(pid);
    cls_rxtok = pid_is_rx_token(pid);
  end

endmodule

// File: rtl/resp_token_reg.sv
module resp_token_reg
  import usb_resp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tok_store,
  input  logic       tok_clear,
  input  logic [7:0] tok_pid,
  output logic [7:0] tok_q,
  output logic       tok_held
);

  always_ff @(posedge clk) begin
    if (!rst_n)         tok_q <= TOK_NONE;
    else if (tok_store) tok_q <= tok_pid;
    else if (tok_clear) tok_q <= TOK_NONE;
  end

  assign tok_held = tok_q != TOK_NONE;

endmodule

// File: rtl/resp_buf_state.sv
module resp_buf_state #(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [LEN_W-1:0] acc_len,
  input  logic [7:0]       acc_token,
  input  logic             release_rx,
  input  logic             load_tx,
  input  logic [LEN_W-1:0] load_len,
  input  logic             send_tx,
  output logic             rx_full_q,
  output logic [LEN_W-1:0] rx_len_q,
  output logic [7:0]       rx_token_q,
  output logic             rx_bank_q,
  output logic             tx_ready_q,
  output logic [LEN_W-1:0] tx_len_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_full_q  <= 1'b0;
      rx_len_q   <= '0;
      rx_token_q <= '0;
      rx_bank_q  <= 1'b0;
    end else if (accept) begin
      rx_full_q  <= 1'b1;
      rx_len_q   <= acc_len;
      rx_token_q <= acc_token;
      rx_bank_q  <= ~rx_bank_q;
    end else if (release_rx) begin
      rx_full_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_ready_q <= 1'b0;
      tx_len_q   <= '0;
    end else if (load_tx) begin
      tx_ready_q <= 1'b1;
      tx_len_q   <= load_len;
    end else if (send_tx) begin
      tx_ready_q <= 1'b0;
    end
  end

endmodule

// File: rtl/resp_addr_regs.sv
module resp_addr_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_pend,
  input  logic [6:0] set_val,
  input  logic       commit,
  output logic [6:0] active_q
);

  logic [6:0] pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        pend_q <= '0;
    else if (set_pend) pend_q <= set_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      active_q <= '0;
    else if (commit) active_q <= pend_q;
  end

endmodule

// File: rtl/usb_txn_responder.sv
module usb_txn_responder
  import usb_resp_pkg::*;
#(
  parameter int BUF_BYTES = 11,
  parameter int MIN_LEN   = 3,
  parameter int LEN_W     = $clog2(BUF_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_end,
  input  logic [7:0]       pkt_pid,
  input  logic [7:0]       pkt_addr,
  input  logic [LEN_W-1:0] pkt_len,
  input  logic             rx_release,
  input  logic             tx_load,
  input  logic [LEN_W-1:0] tx_load_len,
  input  logic             addr_set,
  input  logic [6:0]       addr_set_val,
  output logic             reply_valid,
  output logic [1:0]       reply_kind,
  output logic [LEN_W-1:0] reply_len,
  output logic             rx_full,
  output logic [LEN_W-1:0] rx_len,
  output logic [7:0]       rx_token,
  output logic             rx_bank,
  output logic             tx_ready,
  output logic [6:0]       dev_addr
);

  logic             cls_short, cls_data, cls_match, cls_in, cls_rxtok;
  logic [7:0]       tok_q;
  logic             tok_held;
  logic [LEN_W-1:0] tx_len_q;

  // Named decision events, one per outcome.
  logic ev_ack, ev_nak, ev_send, ev_store, ev_ignore;

  resp_classify #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) i_classify (
    .pid        (pkt_pid),
    .addr_field (pkt_addr),
    .len        (pkt_len),
    .own_addr   (dev_addr),
    .cls_short  (cls_short),
    .cls_data   (cls_data),
    .cls_match  (cls_match),
    .cls_in     (cls_in),
    .cls_rxtok  (cls_rxtok)
  );

  always_comb begin
    ev_ack    = 1'b0;
    ev_nak    = 1'b0;
    ev_send   = 1'b0;
    ev_store  = 1'b0;
    ev_ignore = 1'b0;
    if (pkt_end) begin
      if (cls_short) begin
        ev_ignore = 1'b1;
      end else if (cls_data) begin
        if (!tok_held)     ev_ignore = 1'b1;
        else if (rx_full)  ev_nak    = 1'b1;
        else               ev_ack    = 1'b1;
      end else if (!cls_match) begin
        ev_ignore = 1'b1;
      end else if (cls_in) begin
        if (!tx_ready || rx_full) ev_nak  = 1'b1;
        else                      ev_send = 1'b1;
      end else if (cls_rxtok) begin
        ev_store = 1'b1;
      end else begin
        ev_ignore = 1'b1;
      end
    end
  end

  resp_token_reg i_token (
    .clk       (clk),
    .rst_n     (rst_n),
    .tok_store (ev_store),
    .tok_clear (ev_ignore),
    .tok_pid   (pkt_pid),
    .tok_q     (tok_q),
    .tok_held  (tok_held)
  );

  resp_buf_state #(.LEN_W(LEN_W)) i_bufs (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (ev_ack),
    .acc_len    (pkt_len),
    .acc_token  (tok_q),
    .release_rx (rx_release),
    .load_tx    (tx_load),
    .load_len   (tx_load_len),
    .send_tx    (ev_send),
    .rx_full_q  (rx_full),
    .rx_len_q   (rx_len),
    .rx_token_q (rx_token),
    .rx_bank_q  (rx_bank),
    .tx_ready_q (tx_ready),
    .tx_len_q   (tx_len_q)
  );

  resp_addr_regs i_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_pend (addr_set),
    .set_val  (addr_set_val),
    .commit   (ev_send),
    .active_q (dev_addr)
  );

  reply_kind_e kind_d;

  always_comb begin
    if (ev_send)     kind_d = RK_DATA;
    else if (ev_nak) kind_d = RK_NAK;
    else if (ev_ack) kind_d = RK_ACK;
    else             kind_d = RK_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reply_valid <= 1'b0;
      reply_kind  <= RK_NONE;
      reply_len   <= '0;
    end else begin
      reply_valid <= ev_ack | ev_nak | ev_send;
      reply_kind  <= kind_d;
      reply_len   <= ev_send ? tx_len_q : '0;
    end
  end

endmodule

// File: rtl/usb_txn_responder_chk.sv
module usb_txn_responder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pkt_end,
  input logic       tx_load,
  input logic       reply_valid,
  input logic [1:0] reply_kind,
  input logic       rx_full,
  input logic       rx_bank,
  input logic       tx_ready,
  input logic [6:0] dev_addr,
  input logic       ev_ack,
  input logic       ev_nak,
  input logic       ev_send,
  input logic       ev_store,
  input logic       ev_ignore
);

  a_r2_reply_follows_end: assert property (@(posedge clk) disable iff (!rst_n)
    reply_valid |-> $past(pkt_end));

  a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_ack, ev_nak, ev_send, ev_store, ev_ignore}));

  a_r6_ack_fills_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (reply_valid && reply_kind == 2'd1) |-> (rx_full && rx_bank != $past(rx_bank)));

  a_r6_full_only_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> (reply_valid && reply_kind == 2'd1));

  a_r5_nak_keeps_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (reply_valid && reply_kind == 2'd2) |-> (rx_bank == $past(rx_bank)));

  a_r9_send_frees_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (reply_valid && reply_kind == 2'd3 && !$past(tx_load)) |-> !tx_ready);

  a_r10_addr_on_send: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_addr != $past(dev_addr)) |-> (reply_valid && reply_kind == 2'd3));

endmodule

bind usb_txn_responder usb_txn_responder_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pkt_end     (pkt_end),
  .tx_load     (tx_load),
  .reply_valid (reply_valid),
  .reply_kind  (reply_kind),
  .rx_full     (rx_full),
  .rx_bank     (rx_bank),
  .tx_ready    (tx_ready),
  .dev_addr    (dev_addr),
  .ev_ack      (ev_ack),
  .ev_nak      (ev_nak),
  .ev_send     (ev_send),
  .ev_store    (ev_store),
  .ev_ignore   (ev_ignore)
);

// File: tb/test_usb_txn_responder.sv
module test_usb_txn_responder;

  localparam int LEN_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             pkt_end = 1'b0;
  logic [7:0]       pkt_pid = '0;
  logic [7:0]       pkt_addr = '0;
  logic [LEN_W-1:0] pkt_len = '0;
  logic             rx_release = 1'b0;
  logic             tx_load = 1'b0;
  logic [LEN_W-1:0] tx_load_len = '0;
  logic             addr_set = 1'b0;
  logic [6:0]       addr_set_val = '0;
  logic             reply_valid;
  logic [1:0]       reply_kind;
  logic [LEN_W-1:0] reply_len;
  logic             rx_full;
  logic [LEN_W-1:0] rx_len;
  logic [7:0]       rx_token;
  logic             rx_bank;
  logic             tx_ready;
  logic [6:0]       dev_addr;

  int vec_cnt = 0;
  int miss_cnt = 0;
  int got_valid, got_kind, got_len;

  always #5 clk = ~clk;

  usb_txn_responder i_usb_txn_responder (
    .clk(clk), .rst_n(rst_n), .pkt_end(pkt_end), .pkt_pid(pkt_pid),
    .pkt_addr(pkt_addr), .pkt_len(pkt_len), .rx_release(rx_release),
    .tx_load(tx_load), .tx_load_len(tx_load_len), .addr_set(addr_set),
    .addr_set_val(addr_set_val), .reply_valid(reply_valid),
    .reply_kind(reply_kind), .reply_len(reply_len), .rx_full(rx_full),
    .rx_len(rx_len), .rx_token(rx_token), .rx_bank(rx_bank),
    .tx_ready(tx_ready), .dev_addr(dev_addr)
  );

  task automatic check(input string req, input int act, input int exp);
    vec_cnt++;
    if (act != exp) begin
      miss_cnt++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Presents one packet; captures the reply in the cycle after the strobe
  // and confirms the reply pulse has ended one cycle later (R2).
  task automatic send_pkt(input logic [7:0] pid, input logic [7:0] ab, input int len);
    @(negedge clk);
    pkt_end = 1'b1; pkt_pid = pid; pkt_addr = ab; pkt_len = LEN_W'(len);
    @(posedge clk); #1;
    got_valid = int'(reply_valid); got_kind = int'(reply_kind); got_len = int'(reply_len);
    @(negedge clk);
    pkt_end = 1'b0;
    @(posedge clk); #1;
    check("R2 pulse width", int'(reply_valid), 0);
  endtask

  task automatic expect_reply(input string req, input int kind);
    check({req, " reply valid"}, got_valid, kind != 0 ? 1 : 0);
    if (kind != 0) check({req, " reply kind"}, got_kind, kind);
  endtask

  task automatic pulse_release();
    @(negedge clk); rx_release = 1'b1;
    @(negedge clk); rx_release = 1'b0;
  endtask

  task automatic pulse_load(input int len);
    @(negedge clk); tx_load = 1'b1; tx_load_len = LEN_W'(len);
    @(negedge clk); tx_load = 1'b0;
  endtask

  task automatic pulse_addr(input logic [6:0] a);
    @(negedge clk); addr_set = 1'b1; addr_set_val = a;
    @(negedge clk); addr_set = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reply_valid", int'(reply_valid), 0);
    check("R1 rx_full", int'(rx_full), 0);
    check("R1 tx_ready", int'(tx_ready), 0);
    check("R1 dev_addr", int'(dev_addr), 0);
    send_pkt(8'hC3, 8'h00, 3);
    expect_reply("R1 no token", 0);
  endtask

  task automatic t_setup_data();
    send_pkt(8'h2D, 8'h00, 3);
    expect_reply("R8 setup", 0);
    send_pkt(8'hC3, 8'h55, 10);
    expect_reply("R4 R6 data accept", 1);
    check("R6 rx_len", int'(rx_len), 10);
    check("R6 rx_token", int'(rx_token), 8'h2D);
    check("R6 rx_bank", int'(rx_bank), 1);
    check("R6 rx_full", int'(rx_full), 1);
  endtask

  task automatic t_data_full();
    send_pkt(8'hE1, 8'h00, 3);
    expect_reply("R8 out", 0);
    send_pkt(8'h4B, 8'h00, 6);
    expect_reply("R5 busy", 2);
    check("R5 rx_len", int'(rx_len), 10);
    check("R5 rx_token", int'(rx_token), 8'h2D);
    check("R5 rx_bank", int'(rx_bank), 1);
    pulse_release();
    check("R12 release", int'(rx_full), 0);
    send_pkt(8'h4B, 8'h00, 6);
    expect_reply("R6 retry", 1);
    check("R6 out token", int'(rx_token), 8'hE1);
    check("R6 rx_len", int'(rx_len), 6);
    check("R6 bank back", int'(rx_bank), 0);
    pulse_release();
  endtask

  task automatic t_short();
    send_pkt(8'h2D, 8'h00, 3);
    send_pkt(8'hC3, 8'h00, 2);
    expect_reply("R3 short", 0);
    send_pkt(8'hC3, 8'h00, 3);
    expect_reply("R3 token cleared", 0);
    check("R3 rx_full", int'(rx_full), 0);
  endtask

  task automatic t_in_addr();
    pulse_addr(7'h15);
    check("R10 pending only", int'(dev_addr), 0);
    send_pkt(8'h69, 8'h00, 3);
    expect_reply("R9 nothing loaded", 2);
    check("R10 nak keeps addr", int'(dev_addr), 0);
    pulse_load(5);
    check("R12 tx_ready", int'(tx_ready), 1);
    send_pkt(8'h69, 8'h00, 3);
    expect_reply("R9 send", 3);
    check("R9 reply_len", got_len, 5);
    check("R9 tx freed", int'(tx_ready), 0);
    check("R10 commit", int'(dev_addr), 8'h15);
  endtask

  task automatic t_match();
    send_pkt(8'h2D, 8'h00, 3);
    expect_reply("R7 mismatch", 0);
    send_pkt(8'hC3, 8'h00, 3);
    expect_reply("R7 token cleared", 0);
    send_pkt(8'h2D, 8'h95, 3);
    expect_reply("R7 bit7 ignored", 0);
    send_pkt(8'hC3, 8'h00, 4);
    expect_reply("R7 data after match", 1);
    check("R7 rx_len", int'(rx_len), 4);
  endtask

  task automatic t_in_busy();
    pulse_load(4);
    send_pkt(8'h69, 8'h15, 3);
    expect_reply("R9 rx busy", 2);
    check("R9 tx kept", int'(tx_ready), 1);
    pulse_addr(7'h22);
    send_pkt(8'h69, 8'h15, 3);
    expect_reply("R9 still busy", 2);
    check("R10 nak no commit", int'(dev_addr), 8'h15);
    pulse_release();
    send_pkt(8'h69, 8'h15, 3);
    expect_reply("R9 send", 3);
    check("R9 reply_len", got_len, 4);
    check("R10 commit", int'(dev_addr), 8'h22);
  endtask

  task automatic t_unknown();
    send_pkt(8'h2D, 8'h22, 3);
    send_pkt(8'hA5, 8'h22, 3);
    expect_reply("R11 unknown", 0);
    send_pkt(8'hC3, 8'h22, 3);
    expect_reply("R11 token cleared", 0);
    check("R11 rx_full", int'(rx_full), 0);
    send_pkt(8'h69, 8'h15, 3);
    expect_reply("R7 old address", 0);
  endtask

  initial begin
    #100000;
    miss_cnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_setup_data();
    t_data_full();
    t_short();
    t_in_addr();
    t_match();
    t_in_busy();
    t_unknown();
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
    $finish;
  end

endmodule